// File: doc/BRIEF.md
# Palette-Indexed Cursor Overlay

This block lays a small cursor image over a raster video stream. The image lives in a local byte-wide pixmap memory as 8-bit colour indices, one byte per pixel. A 256-entry palette turns each index into a 16-bit ARGB4444 colour. For every raster pixel the block takes the incoming x/y counters and the data-enable flag. It tests whether the pixel lies inside the programmed cursor rectangle and also inside a separate active-window box. If both hold, it fetches the index, looks up the colour and presents it with a valid flag two cycles later. The enable and raster-timing flags are delayed by the same amount, so a downstream blender sees them aligned.

Software programs the geometry through a small word-indexed register port. It fills a shadow copy of the palette through a dedicated write port and loads the pixmap through a third port. Geometry writes land in shadow registers and reach the pixel path at the next start-of-frame pulse. A palette update is requested by a control bit. The whole shadow palette is then copied to the live palette in the first cycle of vertical blanking, so no frame ever mixes old and new colours.

Top module: `cursor_overlay`

## Requirements
- R1: After reset `ovl_valid`, `ovl_de`, `ovl_argb` and `pal_busy` are all 0. The reset cursor size is 0 by 0, so no pixel is covered until a size is programmed and a start-of-frame pulse arrives.
- R2: Register word 1 (position) takes x from bits 11:0 and y from bits 27:16. Register word 2 (size) takes width from bits 10:0 and height from bits 26:16. Register word 3 takes the row pitch in bytes from bits 11:0. Other bits of these words are ignored.
- R3: A size write whose width or height lies outside 1..128 is dropped as a whole, and the previous size stays in force.
- R4: `ovl_valid` is 1 only for a pixel with `ras_de` high, xpos <= x < xpos+width and ypos <= y < ypos+height. The pixel must also lie inside the active window. Every other pixel gives `ovl_valid` 0 and `ovl_argb` 0.
- R5: Window start (word 4) and window end (word 5) each hold a line number in bits 31:16 and a pixel number in bits 15:0. The window spans start..end with both ends inclusive.
- R6: A covered pixel reads the pixmap byte at ((y-ypos)*pitch + (x-xpos)) mod 2^PIX_AW. It outputs the live palette entry for that byte.
- R7: A pixel presented before clock edge k yields its result on `ovl_valid`/`ovl_argb` after edge k+1. `ovl_de` is `ras_de` delayed by the same two edges.
- R8: After reset the palette entry for index {a,r,g,b} (2 bits each, a in bits 7:6, b in 1:0) is {5a,5r,5g,5b} in ARGB4444 order. In that order alpha is bits 15:12 and blue is bits 3:0.
- R9: Writes to the palette port change no output colour until an update is requested. An update is requested by writing register word 0 with bit 1 set, which raises `pal_busy`. A control write with bit 1 clear requests nothing.
- R10: While an update is pending, the first clock with `ras_vblank` high copies all 256 shadow entries to the live palette at once and clears `pal_busy`.
- R11: Position, size, pitch and window writes change no output until a clock with `ras_sof` high. From the following clock on, the new values apply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register word index |
| cfg_wdata | input | 32 | Register write data |
| pal_we | input | 1 | Shadow palette write strobe |
| pal_idx | input | 8 | Shadow palette entry index |
| pal_wdata | input | 16 | Shadow palette ARGB4444 value |
| pix_we | input | 1 | Pixmap write strobe |
| pix_waddr | input | PIX_AW | Pixmap byte address |
| pix_wdata | input | 8 | Pixmap colour index |
| ras_x | input | COORD_W | Raster pixel counter |
| ras_y | input | COORD_W | Raster line counter |
| ras_de | input | 1 | Raster data enable |
| ras_sof | input | 1 | Start-of-frame pulse |
| ras_vblank | input | 1 | Vertical blanking flag |
| ovl_argb | output | 16 | Cursor colour, ARGB4444 |
| ovl_valid | output | 1 | Cursor covers this pixel |
| ovl_de | output | 1 | Data enable delayed to match the colour |
| pal_busy | output | 1 | Palette update pending |

## Verification
The assertions assume the raster counters are stable for one clock per pixel. They also assume the start-of-frame pulse and vertical blanking arrive as ordinary single-clock or level signals and never inside reset. The stimulus keeps to this in three ways. It drives every input on the falling edge. It issues the start-of-frame and blanking pulses only while `ras_de` is low. It programs the pixmap before any sweep, so every covered pixel reads a defined byte. The sweeps step the raster over a 32 by 16 area and place cursor and window edges inside it. This exercises edge-inclusive and edge-exclusive comparisons on both axes, the 128-pixel width limit, and the data-enable gate.

// File: rtl/cursor_ovl_pkg.sv
package cursor_ovl_pkg;

   localparam int REG_AW = 3;

   localparam logic [REG_AW-1:0] RA_CTRL   = 3'd0;
   localparam logic [REG_AW-1:0] RA_POS    = 3'd1;
   localparam logic [REG_AW-1:0] RA_SIZE   = 3'd2;
   localparam logic [REG_AW-1:0] RA_PITCH  = 3'd3;
   localparam logic [REG_AW-1:0] RA_WSTART = 3'd4;
   localparam logic [REG_AW-1:0] RA_WEND   = 3'd5;

   localparam int CTRL_RELOAD_BIT = 1;

   localparam int POS_W   = 12;
   localparam int DIM_W   = 11;
   localparam int PITCH_W = 12;
   localparam int WIN_W   = 16;
   localparam int IDX_W   = 8;
   localparam int ARGB_W  = 16;
   localparam int PAL_N   = 1 << IDX_W;

   typedef struct packed {
      logic [POS_W-1:0]   xpos;
      logic [POS_W-1:0]   ypos;
      logic [DIM_W-1:0]   w;
      logic [DIM_W-1:0]   h;
      logic [PITCH_W-1:0] pitch;
      logic [WIN_W-1:0]   ws_x;
      logic [WIN_W-1:0]   ws_y;
      logic [WIN_W-1:0]   we_x;
      logic [WIN_W-1:0]   we_y;
   } geom_t;

   function automatic logic [ARGB_W-1:0] default_argb(input logic [IDX_W-1:0] idx);
      logic [3:0] a, r, g, b;
      a = {2'b00, idx[7:6]} * 4'd5;
      r = {2'b00, idx[5:4]} * 4'd5;
      g = {2'b00, idx[3:2]} * 4'd5;
      b = {2'b00, idx[1:0]} * 4'd5;
      return {a, r, g, b};
   endfunction

endpackage

// File: rtl/cursor_regs.sv
module cursor_regs
   import cursor_ovl_pkg::*;
#(
   parameter int MIN_DIM = 1,
   parameter int MAX_DIM = 128
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [REG_AW-1:0] wr_addr,
   input  logic [31:0]       wr_data,
   input  logic              frame_start,
   input  logic              reload_done,
   output geom_t             act,
   output logic              upd_pend
);

   localparam logic [DIM_W-1:0] LO = DIM_W'(MIN_DIM);
   localparam logic [DIM_W-1:0] HI = DIM_W'(MAX_DIM);

   geom_t            shd;
   logic [DIM_W-1:0] new_w, new_h;
   logic             size_ok;

   always_comb begin
      new_w   = wr_data[DIM_W-1:0];
      new_h   = wr_data[16 +: DIM_W];
      size_ok = (new_w >= LO) && (new_w <= HI) && (new_h >= LO) && (new_h <= HI);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shd       <= '0;
         shd.we_x  <= '1;
         shd.we_y  <= '1;
      end else if (wr_en) begin
         unique case (wr_addr)
            RA_POS: begin
               shd.xpos <= wr_data[POS_W-1:0];
               shd.ypos <= wr_data[16 +: POS_W];
            end
            RA_SIZE: begin
               if (size_ok) begin
                  shd.w <= new_w;
                  shd.h <= new_h;
               end
            end
            RA_PITCH:  shd.pitch <= wr_data[PITCH_W-1:0];
            RA_WSTART: begin
               shd.ws_x <= wr_data[WIN_W-1:0];
               shd.ws_y <= wr_data[16 +: WIN_W];
            end
            RA_WEND: begin
               shd.we_x <= wr_data[WIN_W-1:0];
               shd.we_y <= wr_data[16 +: WIN_W];
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act      <= '0;
         act.we_x <= '1;
         act.we_y <= '1;
      end else if (frame_start) begin
         act <= shd;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         upd_pend <= 1'b0;
      else if (wr_en && wr_addr == RA_CTRL && wr_data[CTRL_RELOAD_BIT])
         upd_pend <= 1'b1;
      else if (reload_done)
         upd_pend <= 1'b0;
   end

   assert_size_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (act.w == '0 && act.h == '0) ||
      (act.w >= LO && act.w <= HI && act.h >= LO && act.h <= HI));

   assert_geom_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(frame_start) |-> $stable(act));

   assert_pend_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(upd_pend) |-> $past(reload_done));

endmodule

// File: rtl/cursor_palette.sv
module cursor_palette
   import cursor_ovl_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [ARGB_W-1:0] wr_data,
   input  logic              copy,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [ARGB_W-1:0] rd_data
);

   logic [ARGB_W-1:0] shadow_q [PAL_N];
   logic [ARGB_W-1:0] live_q   [PAL_N];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < PAL_N; i++) shadow_q[i] <= default_argb(IDX_W'(i));
      end else if (wr_en) begin
         shadow_q[wr_idx] <= wr_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < PAL_N; i++) live_q[i] <= default_argb(IDX_W'(i));
      end else if (copy) begin
         live_q <= shadow_q;
      end
   end

   assign rd_data = live_q[rd_idx];

   assert_live_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(copy) |-> $stable(live_q[0]));

endmodule

// File: rtl/cursor_pixmap.sv
module cursor_pixmap
   import cursor_ovl_pkg::*;
#(
   parameter int PIX_AW = 11
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [PIX_AW-1:0] wr_addr,
   input  logic [IDX_W-1:0]  wr_data,
   input  logic [PIX_AW-1:0] rd_addr,
   output logic [IDX_W-1:0]  rd_data
);

   localparam int DEPTH = 1 << PIX_AW;

   logic [IDX_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_addr] <= wr_data;
      rd_data <= mem[rd_addr];
   end

endmodule

// File: rtl/cursor_hit.sv
module cursor_hit
   import cursor_ovl_pkg::*;
#(
   parameter int COORD_W     = 16,
   parameter int PIX_AW      = 11,
   parameter bit CLIP_WINDOW = 1'b1
) (
   input  geom_t              g,
   input  logic [COORD_W-1:0] x,
   input  logic [COORD_W-1:0] y,
   input  logic               de,
   output logic               hit,
   output logic [PIX_AW-1:0]  addr
);

   logic [COORD_W-1:0] dx, dy;
   logic               in_rect, in_win;
   logic [WIN_W-1:0]   x16, y16;

   always_comb begin
      dx      = x - COORD_W'(g.xpos);
      dy      = y - COORD_W'(g.ypos);
      in_rect = (x >= COORD_W'(g.xpos)) && (y >= COORD_W'(g.ypos)) &&
                (dx < COORD_W'(g.w)) && (dy < COORD_W'(g.h));
      addr    = PIX_AW'(dy) * PIX_AW'(g.pitch) + PIX_AW'(dx);
      x16     = WIN_W'(x);
      y16     = WIN_W'(y);
   end

   generate
      if (CLIP_WINDOW) begin : g_clip
         assign in_win = (x16 >= g.ws_x) && (x16 <= g.we_x) &&
                         (y16 >= g.ws_y) && (y16 <= g.we_y);
      end else begin : g_noclip
         logic unused_win;
         assign unused_win = ^{x16, y16, g.ws_x, g.ws_y, g.we_x, g.we_y};
         assign in_win = 1'b1;
      end
   endgenerate

   assign hit = de && in_rect && in_win;

endmodule

// File: rtl/cursor_overlay.sv
module cursor_overlay
   import cursor_ovl_pkg::*;
#(
   parameter int COORD_W     = 16,
   parameter int PIX_AW      = 11,
   parameter int MIN_DIM     = 1,
   parameter int MAX_DIM     = 128,
   parameter bit CLIP_WINDOW = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_we,
   input  logic [2:0]         cfg_addr,
   input  logic [31:0]        cfg_wdata,
   input  logic               pal_we,
   input  logic [7:0]         pal_idx,
   input  logic [15:0]        pal_wdata,
   input  logic               pix_we,
   input  logic [PIX_AW-1:0]  pix_waddr,
   input  logic [7:0]         pix_wdata,
   input  logic [COORD_W-1:0] ras_x,
   input  logic [COORD_W-1:0] ras_y,
   input  logic               ras_de,
   input  logic               ras_sof,
   input  logic               ras_vblank,
   output logic [15:0]        ovl_argb,
   output logic               ovl_valid,
   output logic               ovl_de,
   output logic               pal_busy
);

   if (COORD_W < POS_W || COORD_W > WIN_W) begin : g_bad_coord
      $error("cursor_overlay: COORD_W must lie in 12..16");
   end
   if (PIX_AW < 4 || PIX_AW > 14) begin : g_bad_aw
      $error("cursor_overlay: PIX_AW must lie in 4..14");
   end
   if (MIN_DIM < 1 || MAX_DIM < MIN_DIM || MAX_DIM >= (1 << DIM_W)) begin : g_bad_dim
      $error("cursor_overlay: dimension limits out of range");
   end

   geom_t             act;
   logic              reload;
   logic              hit_s0, hit_s1, de_s1;
   logic [PIX_AW-1:0] rd_addr;
   logic [IDX_W-1:0]  pix_idx;
   logic [ARGB_W-1:0] pal_colour;

   assign reload = pal_busy && ras_vblank;

   cursor_regs #(.MIN_DIM(MIN_DIM), .MAX_DIM(MAX_DIM)) u_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en       (cfg_we),
      .wr_addr     (cfg_addr),
      .wr_data     (cfg_wdata),
      .frame_start (ras_sof),
      .reload_done (reload),
      .act         (act),
      .upd_pend    (pal_busy)
   );

   cursor_hit #(.COORD_W(COORD_W), .PIX_AW(PIX_AW), .CLIP_WINDOW(CLIP_WINDOW)) u_hit (
      .g    (act),
      .x    (ras_x),
      .y    (ras_y),
      .de   (ras_de),
      .hit  (hit_s0),
      .addr (rd_addr)
   );

   cursor_pixmap #(.PIX_AW(PIX_AW)) u_pixmap (
      .clk     (clk),
      .wr_en   (pix_we),
      .wr_addr (pix_waddr),
      .wr_data (pix_wdata),
      .rd_addr (rd_addr),
      .rd_data (pix_idx)
   );

   cursor_palette u_palette (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (pal_we),
      .wr_idx  (pal_idx),
      .wr_data (pal_wdata),
      .copy    (reload),
      .rd_idx  (pix_idx),
      .rd_data (pal_colour)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hit_s1    <= 1'b0;
         de_s1     <= 1'b0;
         ovl_valid <= 1'b0;
         ovl_de    <= 1'b0;
         ovl_argb  <= '0;
      end else begin
         hit_s1    <= hit_s0;
         de_s1     <= ras_de;
         ovl_valid <= hit_s1;
         ovl_de    <= de_s1;
         ovl_argb  <= hit_s1 ? pal_colour : '0;
      end
   end

   assert_blank_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !ovl_valid |-> ovl_argb == '0);

   assert_valid_has_de_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ovl_valid |-> ovl_de);

endmodule

// File: tb/cursor_overlay_bench.sv
module cursor_overlay_bench;

   localparam int AW   = 11;
   localparam int MEMN = 1 << AW;
   localparam int COLS = 32;
   localparam int ROWS = 16;
   localparam int NPIX = COLS * ROWS;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [2:0]  cfg_addr = '0;
   logic [31:0] cfg_wdata = '0;
   logic        pal_we = 1'b0;
   logic [7:0]  pal_idx = '0;
   logic [15:0] pal_wdata = '0;
   logic        pix_we = 1'b0;
   logic [AW-1:0] pix_waddr = '0;
   logic [7:0]  pix_wdata = '0;
   logic [15:0] ras_x = '0, ras_y = '0;
   logic        ras_de = 1'b0, ras_sof = 1'b0, ras_vblank = 1'b0;
   logic [15:0] ovl_argb;
   logic        ovl_valid, ovl_de, pal_busy;

   always #2.5 clk = ~clk;

   cursor_overlay u_cursor_overlay (
      .clk(clk), .rst_n(rst_n),
      .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
      .pal_we(pal_we), .pal_idx(pal_idx), .pal_wdata(pal_wdata),
      .pix_we(pix_we), .pix_waddr(pix_waddr), .pix_wdata(pix_wdata),
      .ras_x(ras_x), .ras_y(ras_y), .ras_de(ras_de),
      .ras_sof(ras_sof), .ras_vblank(ras_vblank),
      .ovl_argb(ovl_argb), .ovl_valid(ovl_valid), .ovl_de(ovl_de),
      .pal_busy(pal_busy)
   );

   int checks = 0, errors = 0;
   bit done = 0;

   // bench model
   int s_x, s_y, s_w, s_h, s_p, s_wsx, s_wsy, s_wex, s_wey;
   int a_x, a_y, a_w, a_h, a_p, a_wsx, a_wsy, a_wex, a_wey;
   bit m_pend;
   logic [7:0]  bmem [MEMN];
   logic [15:0] shad [256];
   logic [15:0] live [256];
   logic        e_v [NPIX];
   logic        e_d [NPIX];
   logic [15:0] e_c [NPIX];

   function automatic logic [15:0] dflt(int i);
      return {4'(((i >> 6) & 3) * 5), 4'(((i >> 4) & 3) * 5),
              4'(((i >> 2) & 3) * 5), 4'((i & 3) * 5)};
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr_reg(logic [2:0] a, logic [31:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
      case (a)
         3'd0: if (d[1]) m_pend = 1;
         3'd1: begin s_x = int'(d[11:0]); s_y = int'(d[27:16]); end
         3'd2: if (d[10:0] >= 1 && d[10:0] <= 128 && d[26:16] >= 1 && d[26:16] <= 128) begin
                  s_w = int'(d[10:0]); s_h = int'(d[26:16]);
               end
         3'd3: s_p = int'(d[11:0]);
         3'd4: begin s_wsx = int'(d[15:0]); s_wsy = int'(d[31:16]); end
         3'd5: begin s_wex = int'(d[15:0]); s_wey = int'(d[31:16]); end
         default: ;
      endcase
   endtask

   task automatic pulse_sof();
      @(negedge clk); ras_sof = 1'b1;
      @(negedge clk); ras_sof = 1'b0;
      a_x = s_x; a_y = s_y; a_w = s_w; a_h = s_h; a_p = s_p;
      a_wsx = s_wsx; a_wsy = s_wsy; a_wex = s_wex; a_wey = s_wey;
   endtask

   task automatic pulse_vblank();
      @(negedge clk); ras_vblank = 1'b1;
      @(negedge clk); ras_vblank = 1'b0;
      if (m_pend) begin
         for (int i = 0; i < 256; i++) live[i] = shad[i];
         m_pend = 0;
      end
   endtask

   task automatic sweep(string tag);
      for (int i = 0; i < NPIX + 2; i++) begin
         @(negedge clk);
         if (i >= 2) begin
            check({tag, " valid"}, 32'(ovl_valid), 32'(e_v[i-2]));
            check({tag, " colour"}, 32'(ovl_argb), 32'(e_c[i-2]));
            check("R7 de delay", 32'(ovl_de), 32'(e_d[i-2]));
         end
         if (i < NPIX) begin
            int px, py, ad;
            bit de, h;
            px = i % COLS; py = i / COLS;
            de = (px != COLS - 1);
            ras_x = 16'(px); ras_y = 16'(py); ras_de = de;
            h = de && px >= a_x && (px - a_x) < a_w && py >= a_y && (py - a_y) < a_h &&
                px >= a_wsx && px <= a_wex && py >= a_wsy && py <= a_wey;
            ad = ((py - a_y) * a_p + (px - a_x)) & (MEMN - 1);
            e_v[i] = h;
            e_d[i] = de;
            e_c[i] = h ? live[bmem[ad]] : 16'h0;
         end else begin
            ras_de = 1'b0;
         end
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      s_x = 0; s_y = 0; s_w = 0; s_h = 0; s_p = 0;
      s_wsx = 0; s_wsy = 0; s_wex = 65535; s_wey = 65535;
      a_x = 0; a_y = 0; a_w = 0; a_h = 0; a_p = 0;
      a_wsx = 0; a_wsy = 0; a_wex = 65535; a_wey = 65535;
      m_pend = 0;
      for (int i = 0; i < 256; i++) begin shad[i] = dflt(i); live[i] = dflt(i); end

      repeat (3) @(negedge clk);
      check("R1 valid", 32'(ovl_valid), 0);
      check("R1 colour", 32'(ovl_argb), 0);
      check("R1 de", 32'(ovl_de), 0);
      check("R1 busy", 32'(pal_busy), 0);
      rst_n = 1'b1;

      for (int a = 0; a < MEMN; a++) begin
         @(negedge clk);
         pix_we = 1'b1; pix_waddr = AW'(a); pix_wdata = 8'((a * 37 + 11) & 255);
         bmem[a] = 8'((a * 37 + 11) & 255);
      end
      @(negedge clk); pix_we = 1'b0;

      // R1: reset geometry covers nothing
      sweep("R1");

      // R2 R5: junk above fields; window clips left and bottom edges
      wr_reg(3'd1, 32'hF003_F005);
      wr_reg(3'd2, 32'hF806_F80A);
      wr_reg(3'd3, 32'd12);
      wr_reg(3'd4, {16'd0, 16'd7});
      wr_reg(3'd5, {16'd6, 16'd40});
      sweep("R11 before sof");
      pulse_sof();
      sweep("R2 R4 R5 R6 default palette R8");

      // boundary: width 128, window end inclusive at x=25, y start 9
      wr_reg(3'd1, {16'd8, 16'd20});
      wr_reg(3'd2, {16'd2, 16'd128});
      wr_reg(3'd3, 32'd200);
      wr_reg(3'd4, {16'd9, 16'd0});
      wr_reg(3'd5, {16'd15, 16'd25});
      pulse_sof();
      sweep("R4 R5 R6 width 128");

      // R3: out-of-range sizes dropped
      wr_reg(3'd2, {16'd2, 16'd129});
      wr_reg(3'd2, {16'd0, 16'd5});
      pulse_sof();
      sweep("R3 size kept");

      // R3: 1x1 accepted at the lower limit
      wr_reg(3'd1, {16'd4, 16'd3});
      wr_reg(3'd2, {16'd1, 16'd1});
      wr_reg(3'd4, 32'h0);
      wr_reg(3'd5, 32'hFFFF_FFFF);
      pulse_sof();
      sweep("R3 1x1");

      // palette: shadow writes, no update yet
      wr_reg(3'd1, {16'd2, 16'd1});
      wr_reg(3'd2, {16'd12, 16'd30});
      wr_reg(3'd3, 32'd40);
      pulse_sof();
      for (int i = 0; i < 256; i++) begin
         @(negedge clk);
         pal_we = 1'b1; pal_idx = 8'(i); pal_wdata = 16'((i * 4099 + 7) & 16'hFFFF);
         shad[i] = 16'((i * 4099 + 7) & 16'hFFFF);
      end
      @(negedge clk); pal_we = 1'b0;
      wr_reg(3'd0, 32'h1);
      check("R9 no request busy", 32'(pal_busy), 0);
      pulse_vblank();
      sweep("R9 shadow hidden");
      wr_reg(3'd0, 32'h2);
      check("R9 busy set", 32'(pal_busy), 1);
      sweep("R9 pending hidden");
      pulse_vblank();
      check("R10 busy clear", 32'(pal_busy), 0);
      sweep("R10 new palette");

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule